// File: doc/BRIEF.md
# Start-Triggered Register Add Sequencer

This block pairs a three-register datapath with a hardwired three-state controller. While it sits idle the controller holds all three registers cleared. A one-cycle start request sends it through two steps. The first step captures two operands from the input pins into the operand registers. The second step writes their sum into a result register that is one bit wider than the operands. The controller then stays in the sum step, holding the result, until the completion input `condZ` is raised. At that point it goes back to idle, and the idle step clears the registers again.

The controller is built twice from the same flowchart. One copy holds its state in one flip-flop per state. The other copy holds it in a two-bit binary register followed by a 2-to-4 decoder. The one-hot copy drives the datapath. The strobes of the binary copy are brought out on their own pins, so the two encodings can be compared cycle by cycle. The state codes are idle = 00, operand load = 01 and sum load = 10. Code 11 is unused, and the next-state equations send it to idle.

Top module: `addseq_top`

## Requirements
- R1: After a synchronous reset `clear` is 1, `load1` and `load2` are 0, and `sum` is 0.
- R2: In the idle step, while `start` is 0, the controller stays idle: `clear` stays 1 on every cycle and `sum` stays 0.
- R3: When `start` is 1 during an idle cycle, the next cycle asserts `load1` and only `load1`.
- R4: A `load1` cycle is always followed by a `load2` cycle, whatever `start` and `condZ` are.
- R5: Two cycles after a `load1` cycle, `sum` equals opA + opB as sampled in that `load1` cycle. The addition is zero-extended to W+1 bits, so the carry is kept. Operand changes after that cycle do not alter `sum`.
- R6: While `load2` is asserted and `condZ` is 0, the next cycle again asserts `load2` and `sum` holds its value.
- R7: A `load2` cycle with `condZ` = 1 is followed by a `clear` cycle, and `sum` reads 0 one cycle after that.
- R8: On every cycle after reset, exactly one of `clear`, `load1` and `load2` is 1.
- R9: On every cycle, `encClear`, `encLoad1` and `encLoad2` from the binary-coded controller equal `clear`, `load1` and `load2`.
- R10: `start` has no effect outside the idle step. Held at 1 through the operand load and sum steps, it neither skips nor repeats a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin request, sampled in the idle step |
| opA | input | W | First operand |
| opB | input | W | Second operand |
| condZ | input | 1 | Completion condition, sampled in the sum step |
| sum | output | W+1 | Result register |
| clear | output | 1 | Idle strobe from the one-hot controller |
| load1 | output | 1 | Operand-load strobe from the one-hot controller |
| load2 | output | 1 | Sum-load strobe from the one-hot controller |
| encClear | output | 1 | Idle strobe from the binary-coded controller |
| encLoad1 | output | 1 | Operand-load strobe from the binary-coded controller |
| encLoad2 | output | 1 | Sum-load strobe from the binary-coded controller |

## Verification
The hardest condition to create from the pins is a disagreement between the two encodings on a rare path. Such paths include a dwell of several cycles in the sum step with `start` held high, and a return to idle that is followed at once by a new start. The directed runs create these paths on purpose. They vary the dwell length from zero to several cycles, hold `start` high through the operand and sum steps, and begin a new run in the first idle cycle after a return. A per-cycle monitor compares the strobes of both controllers and checks that only one strobe is active.

// File: rtl/addseq_pkg.sv
package addseq_pkg;
  typedef struct packed {
    logic clr;
    logic ld1;
    logic ld2;
  } strobe_t;
endpackage

// File: rtl/addseq_ctrl_onehot.sv
module addseq_ctrl_onehot
  import addseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    condZ,
  output strobe_t strobes
);
  localparam int NS = 3;
  localparam int IA = 0;
  localparam int IB = 1;
  localparam int IC = 2;

  logic [NS-1:0] stateFf;
  logic [NS-1:0] nextFf;
  logic idleStay, idleGo, sumStay, sumDone;

  // decision at A: demux on start, enabled by the A flip-flop
  assign idleStay = stateFf[IA] & ~start;
  assign idleGo   = stateFf[IA] &  start;
  // decision at C: demux on condZ, enabled by the C flip-flop
  assign sumStay  = stateFf[IC] & ~condZ;
  assign sumDone  = stateFf[IC] &  condZ;

  // joining paths are ORed into each flip-flop input
  always_comb begin
    nextFf     = '0;
    nextFf[IA] = idleStay | sumDone;
    nextFf[IB] = idleGo;
    nextFf[IC] = stateFf[IB] | sumStay;
  end

  always_ff @(posedge clk) begin
    if (rst) stateFf <= NS'(1 << IA);
    else     stateFf <= nextFf;
  end

  assign strobes.clr = stateFf[IA];
  assign strobes.ld1 = stateFf[IB];
  assign strobes.ld2 = stateFf[IC];
endmodule

// File: rtl/addseq_ctrl_coded.sv
module addseq_ctrl_coded
  import addseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    condZ,
  output strobe_t strobes
);
  localparam int CW = 2;
  localparam int ND = 1 << CW;

  logic [CW-1:0] stateReg;
  logic [ND-1:0] dec;
  logic d0, d1;

  // 2-to-4 decoder on the sequence register
  generate
    for (genvar i = 0; i < ND; i++) begin : g_dec
      assign dec[i] = (stateReg == CW'(i));
    end
  endgenerate

  // code 11 decodes to none of A, B, C, so both bits fall to 0
  assign d0 = dec[0] & start;
  assign d1 = dec[1] | (dec[2] & ~condZ);

  always_ff @(posedge clk) begin
    if (rst) stateReg <= '0;
    else     stateReg <= {d1, d0};
  end

  assign strobes.clr = dec[0];
  assign strobes.ld1 = dec[1];
  assign strobes.ld2 = dec[2];
endmodule

// File: rtl/addseq_datapath.sv
module addseq_datapath
  import addseq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  strobe_t      strobes,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W:0]   sum
);
  localparam int SW = W + 1;

  logic [W-1:0]  regA, regB;
  logic [SW-1:0] regSum;

  always_ff @(posedge clk) begin
    if (rst || strobes.clr) begin
      regA   <= '0;
      regB   <= '0;
      regSum <= '0;
    end else begin
      if (strobes.ld1) begin
        regA <= opA;
        regB <= opB;
      end
      if (strobes.ld2) regSum <= SW'(regA) + SW'(regB);
    end
  end

  assign sum = regSum;
endmodule

// File: rtl/addseq_top.sv
module addseq_top
  import addseq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         condZ,
  output logic [W:0]   sum,
  output logic         clear,
  output logic         load1,
  output logic         load2,
  output logic         encClear,
  output logic         encLoad1,
  output logic         encLoad2
);
  strobe_t ohStrobes;
  strobe_t encStrobes;

  addseq_ctrl_onehot u_onehot (
    .clk(clk), .rst(rst), .start(start), .condZ(condZ), .strobes(ohStrobes)
  );

  addseq_ctrl_coded u_coded (
    .clk(clk), .rst(rst), .start(start), .condZ(condZ), .strobes(encStrobes)
  );

  addseq_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .strobes(ohStrobes), .opA(opA), .opB(opB), .sum(sum)
  );

  assign clear    = ohStrobes.clr;
  assign load1    = ohStrobes.ld1;
  assign load2    = ohStrobes.ld2;
  assign encClear = encStrobes.clr;
  assign encLoad1 = encStrobes.ld1;
  assign encLoad2 = encStrobes.ld2;
endmodule

// File: rtl/addseq_top_checks.sv
module addseq_top_checks #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         condZ,
  input logic [W:0]   sum,
  input logic         clear,
  input logic         load1,
  input logic         load2,
  input logic         encClear,
  input logic         encLoad1,
  input logic         encLoad2
);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (clear && !start) |=> (clear && sum == '0));

  a_r3_start_go: assert property (@(posedge clk) disable iff (rst)
    (clear && start) |=> (load1 && !clear && !load2));

  a_r4_b_to_c: assert property (@(posedge clk) disable iff (rst)
    load1 |=> load2);

  a_r5_sum: assert property (@(posedge clk) disable iff (rst)
    load1 |=> ##1 (sum == ((W+1)'($past(opA, 2)) + (W+1)'($past(opB, 2)))));

  a_r6_dwell: assert property (@(posedge clk) disable iff (rst)
    (load2 && !condZ && $past(load2)) |=> (load2 && $stable(sum)));

  a_r7_exit: assert property (@(posedge clk) disable iff (rst)
    (load2 && condZ) |=> clear);

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({clear, load1, load2}) == 1);

  a_r9_agree: assert property (@(posedge clk) disable iff (rst)
    {encClear, encLoad1, encLoad2} == {clear, load1, load2});
endmodule

bind addseq_top addseq_top_checks #(.W(W)) u_checks (
  .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB), .condZ(condZ),
  .sum(sum), .clear(clear), .load1(load1), .load2(load2),
  .encClear(encClear), .encLoad1(encLoad1), .encLoad2(encLoad2)
);

// File: tb/addseq_top_test.sv
module addseq_top_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         condZ = 1'b0;
  logic [W:0]   sum;
  logic         clear, load1, load2, encClear, encLoad1, encLoad2;

  int checks = 0;
  int errors = 0;
  logic monOn = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  addseq_top #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB), .condZ(condZ),
    .sum(sum), .clear(clear), .load1(load1), .load2(load2),
    .encClear(encClear), .encLoad1(encLoad1), .encLoad2(encLoad2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // R8 and R9 every cycle after reset
  always @(negedge clk) begin
    if (monOn && !rst) begin
      check("R8 one strobe", 32'($countones({clear, load1, load2})), 32'd1);
      check("R9 encodings agree", {29'd0, encClear, encLoad1, encLoad2},
            {29'd0, clear, load1, load2});
    end
  end

  task automatic doReset();
    rst = 1'b1; start = 1'b0; condZ = 1'b0;
    tick(); tick();
    rst = 1'b0;
    check("R1 clear", 32'(clear), 32'd1);
    check("R1 loads", {30'd0, load1, load2}, 32'd0);
    check("R1 sum", 32'(sum), 32'd0);
    monOn = 1'b1;
  endtask

  task automatic idleHold(input int n);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      opA = W'(i * 37 + 5); opB = W'(i * 11 + 3);
      tick();
      check("R2 stays idle", 32'(clear), 32'd1);
      check("R2 sum zero", 32'(sum), 32'd0);
    end
  endtask

  // one full run; enters with the design in an idle cycle
  task automatic runAdd(input logic [W-1:0] a, input logic [W-1:0] b,
                        input int dwell, input logic keepStart);
    logic [W:0] exp;
    exp = (W+1)'(a) + (W+1)'(b);
    check("R3 idle before start", 32'(clear), 32'd1);
    start = 1'b1; opA = a; opB = b; condZ = 1'b0;
    tick();
    check("R3 load1 only", {29'd0, clear, load1, load2}, 32'b010);
    start = keepStart; condZ = 1'b1;
    tick();
    check("R4 load2 after load1", {29'd0, clear, load1, load2}, 32'b001);
    opA = ~a; opB = a ^ b;
    condZ = (dwell == 0);
    for (int i = 0; i < dwell; i++) begin
      start = keepStart;
      tick();
      check("R6 dwell in sum step", 32'(load2), 32'd1);
      if (keepStart) check("R10 start ignored", 32'(load2), 32'd1);
      check("R5 sum with carry", 32'(sum), 32'(exp));
      condZ = (i == dwell - 1);
    end
    start = 1'b0;
    tick();
    condZ = 1'b0;
    check("R7 clear after condZ", 32'(clear), 32'd1);
    check("R5 sum held", 32'(sum), 32'(exp));
  endtask

  task automatic checkCleared();
    tick();
    check("R7 sum cleared", 32'(sum), 32'd0);
    check("R7 still idle", 32'(clear), 32'd1);
  endtask

  task automatic backToBack();
    runAdd(8'd3, 8'd5, 1, 1'b0);
    // new start in the very first idle cycle after return
    runAdd(8'h80, 8'h80, 2, 1'b1);
    checkCleared();
  endtask

  initial begin
    tick();
    doReset();
    idleHold(5);
    runAdd(8'hFF, 8'hFF, 3, 1'b0);
    checkCleared();
    runAdd(8'h00, 8'h00, 0, 1'b0);
    checkCleared();
    runAdd(8'h12, 8'hE7, 4, 1'b1);
    checkCleared();
    backToBack();
    idleHold(3);
    doReset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule